// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

A register-mapped general purpose I/O block for up to 32 pins. Each pin can be used as an input or an output. Each pin can also raise an interrupt on a high level, a low level, a rising edge, a falling edge or any transition. A single 32-bit register port gives access to the block. It has a word address, a write strobe, write data and combinational read data.

Incoming pin levels pass through a two-stage synchroniser. Per-pin trigger logic then produces raw status bits. Edge triggers are latched until software clears them with a write-one-to-clear register. Level triggers follow the synchronised pin. A per-pin enable masks the status into a pending set, and the OR of that set drives one interrupt line.

A read-only revision word is set by a parameter. Any-transition triggering exists only when that revision is 3 or more.

Register word indices (byte offset / 4):

| Index | Register |
|-------|----------|
| 0 | pin level |
| 1 | direction |
| 2 | enable |
| 3 | status |
| 4 | pending |
| 5 | clear |
| 6 | trigger kind |
| 7 | polarity |
| 8 | revision |
| 9 | any-edge |

Top module: `pic_gpio_top`

## Requirements
- R1: Direction (word 1) bit 1 means input and bit 0 means output. The register resets to all ones. pin_oe is the inverse of the direction bits.
- R2: Writing word 0 sets pin_out for every pin. Reading word 0 returns the output register for output pins and the synchronised pin_in for input pins.
- R3: The enable register (word 2) resets to zero, so irq is low after reset.
- R4: With trigger kind (word 6) bit 0, a pin is level triggered. Its status bit equals 1 when the synchronised pin matches polarity (word 7: 1 high, 0 low), and it follows the pin. Writes to clear do not hold it low.
- R5: With trigger kind bit 1 and any-edge bit 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets the status bit. The bit stays set after the pin returns.
- R6: With trigger kind bit 1 and any-edge (word 9) bit 1, both rising and falling transitions set the status bit. Word 9 reads back as written.
- R7: Writing word 5 clears each edge status bit whose data bit is 1. Zero bits leave status unchanged. Word 5 reads as zero.
- R8: Status (word 3) shows raw triggers regardless of enable. Pending (word 4) equals status AND enable. Writes to words 3 and 4 have no effect.
- R9: irq is high exactly when some pending bit is set.
- R10: Word 8 returns the REVISION parameter (default 3), and writes to it are ignored.
- R11: With REVISION below 3, word 9 reads zero, writes to it are ignored, and edge pins trigger only on their polarity edge.
- R12: Reads of unmapped words return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_word | input | 4 | register word index |
| bus_we | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from bus_word |
| pin_in | input | NPINS | pin levels |
| pin_out | output | NPINS | driven levels |
| pin_oe | output | NPINS | output enable, 1 drives the pin |
| irq | output | 1 | combined interrupt |

## Verification
The in-RTL assertions check several rules on every cycle: the zero enable after reset, that a detected edge always lands in status, that a clear without a new event empties an edge status bit, and that the any-edge register stays zero on early revisions. The bench scenarios are needed for the rest. They show level status following the pin under both polarities, edges that persist after the pin returns, selective clearing, masking into pending and irq, and the side-by-side difference between a revision 3 and a revision 2 instance given the same stimulus.

// File: rtl/pic_pkg.sv
// Package: register word indices and bus width shared by the GPIO block.
// Assumes a word-addressed register port of 4 index bits.
package pic_pkg;
    localparam int BUS_W = 32;
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] W_LEVEL  = 4'd0;
    localparam logic [IDX_W-1:0] W_DIR    = 4'd1;
    localparam logic [IDX_W-1:0] W_ENABLE = 4'd2;
    localparam logic [IDX_W-1:0] W_STATUS = 4'd3;
    localparam logic [IDX_W-1:0] W_PEND   = 4'd4;
    localparam logic [IDX_W-1:0] W_CLEAR  = 4'd5;
    localparam logic [IDX_W-1:0] W_KIND   = 4'd6;
    localparam logic [IDX_W-1:0] W_POL    = 4'd7;
    localparam logic [IDX_W-1:0] W_REV    = 4'd8;
    localparam logic [IDX_W-1:0] W_ANY    = 4'd9;
endpackage

// File: rtl/pic_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pic_trigger.sv
// Module: per-pin trigger detection producing raw status bits.
// Assumes lvl is already synchronised. Edge status is sticky until cleared;
// a new event in the same cycle as a clear wins. Level status follows lvl.
module pic_trigger #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] any_edge,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    logic [W-1:0] prev;

    // Remember last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, evt, match;
        assign rise  = lvl[i] & ~prev[i];
        assign fall  = ~lvl[i] & prev[i];
        assign evt   = any_edge[i] ? (rise | fall) : (pol[i] ? rise : fall);
        assign match = pol[i] ? lvl[i] : ~lvl[i];

        // Update one pin's status according to its trigger kind.
        always_ff @(posedge clk) begin
            if (!rst_n)           status[i] <= 1'b0;
            else if (!edge_sel[i]) status[i] <= match;
            else                   status[i] <= (status[i] & ~clr[i]) | evt;
        end

        // R5
        edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[i] && !any_edge[i] && (pol[i] ? (lvl[i] && !prev[i]) : (!lvl[i] && prev[i])))
            |=> status[i]);
        // R6
        any_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[i] && any_edge[i] && (lvl[i] != prev[i])) |=> status[i]);
        // R7
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[i] && clr[i] && (lvl[i] == prev[i])) |=> !status[i]);
    end
endmodule

// File: rtl/pic_gpio_top.sv
// Module: GPIO controller top. Holds the configuration registers, the
// read mux and the interrupt combine. Assumes NPINS <= 32 and a
// single-cycle register port with combinational read data.
module pic_gpio_top
    import pic_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int REVISION = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  bus_word,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam bit HAS_ANY = (REVISION >= 3);

    logic [NPINS-1:0] out_q, dir_q, en_q, kind_q, pol_q, any_q;
    logic [NPINS-1:0] lvl_s, status, clr, pend, wd;

    assign wd = bus_wdata[NPINS-1:0];

    pic_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s)
    );

    // Clear strobe: one-cycle pulse of the written ones.
    assign clr = (bus_we && bus_word == W_CLEAR) ? wd : '0;

    pic_trigger #(.W(NPINS)) u_trig (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .edge_sel(kind_q),
        .pol(pol_q), .any_edge(any_q), .clr(clr), .status(status)
    );

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '1;
            en_q   <= '0;
            kind_q <= '0;
            pol_q  <= '0;
            any_q  <= '0;
        end else if (bus_we) begin
            case (bus_word)
                W_LEVEL:  out_q  <= wd;
                W_DIR:    dir_q  <= wd;
                W_ENABLE: en_q   <= wd;
                W_KIND:   kind_q <= wd;
                W_POL:    pol_q  <= wd;
                W_ANY:    if (HAS_ANY) any_q <= wd;
                default:  ;
            endcase
        end
    end

    assign pend    = status & en_q;
    assign irq     = |pend;
    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    // Read mux with zero extension to the bus width.
    always_comb begin
        logic [NPINS-1:0] sel;
        sel = '0;
        bus_rdata = '0;
        case (bus_word)
            W_LEVEL:  sel = (lvl_s & dir_q) | (out_q & ~dir_q);
            W_DIR:    sel = dir_q;
            W_ENABLE: sel = en_q;
            W_STATUS: sel = status;
            W_PEND:   sel = pend;
            W_KIND:   sel = kind_q;
            W_POL:    sel = pol_q;
            W_ANY:    sel = any_q;
            default:  sel = '0;
        endcase
        bus_rdata[NPINS-1:0] = sel;
        if (bus_word == W_REV) bus_rdata = BUS_W'(REVISION);
    end

    // R3
    en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && !irq));
    // R11
    any_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_ANY |-> (any_q == '0));
    // R9
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == W_PEND) |-> (irq == (bus_rdata != '0)));
endmodule

// File: tb/test_pic_gpio_top.sv
module test_pic_gpio_top;
    import pic_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  bus_word = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata2;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pout2, poe2;
    logic        irq, irq2;

    always #2 clk = ~clk;

    pic_gpio_top #(.NPINS(32), .REVISION(3)) i_pic_gpio_top (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );
    pic_gpio_top #(.NPINS(32), .REVISION(2)) i_pic_gpio_top_rev2 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata2), .pin_in(pin_in),
        .pin_out(pout2), .pin_oe(poe2), .irq(irq2)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 pin_out, 3 pin_oe, 4 rdata rev2
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic wr(input logic [3:0] w, input logic [31:0] d);
        @(posedge clk); #1;
        bus_word = w; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic expect_sig(input int kind, input logic [3:0] w,
                              input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_word = w;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] w, input logic [31:0] e, input string tag);
        expect_sig(0, w, e, tag);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(posedge clk); #1;
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    // Monitor: pop expected items and compare against design outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {31'd0, irq};
                    2: act = pin_out;
                    3: act = pin_oe;
                    default: act = rdata2;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state
        rd(W_DIR, 32'hFFFF_FFFF, "R1 dir reset");
        expect_sig(3, W_DIR, 32'h0, "R1 oe reset");
        rd(W_ENABLE, 32'h0, "R3 enable reset");
        expect_sig(1, W_ENABLE, 32'h0, "R3 irq reset");
        rd(W_REV, 32'd3, "R10 revision");
        expect_sig(4, W_REV, 32'd2, "R11 rev2 revision");
        // Direction and output value
        set_pins(32'h0000_0005);
        wr(W_DIR, 32'hFFFF_FF0F);
        expect_sig(3, W_DIR, 32'h0000_00F0, "R1 oe");
        wr(W_LEVEL, 32'h0000_00A0);
        expect_sig(2, W_LEVEL, 32'h0000_00A0, "R2 pin_out");
        rd(W_LEVEL, 32'h0000_00A5, "R2 level read");
        // Level triggering
        rd(W_STATUS, 32'hFFFF_FFFA, "R4 level low");
        wr(W_POL, 32'hFFFF_FFFF);
        rd(W_STATUS, 32'h0000_0005, "R4 level high");
        wr(W_CLEAR, 32'h0000_0005);
        rd(W_STATUS, 32'h0000_0005, "R4 clear no hold");
        // Enable, pending, irq
        wr(W_ENABLE, 32'h0000_0001);
        rd(W_PEND, 32'h0000_0001, "R8 pending");
        expect_sig(1, W_PEND, 32'h1, "R9 irq high");
        wr(W_STATUS, 32'h0);
        rd(W_STATUS, 32'h0000_0005, "R8 status write ignored");
        wr(W_ENABLE, 32'h0);
        expect_sig(1, W_PEND, 32'h0, "R9 irq low");
        // Edge triggering
        wr(W_KIND, 32'hFFFF_FFFF);
        wr(W_CLEAR, 32'hFFFF_FFFF);
        rd(W_STATUS, 32'h0, "R7 clear all");
        set_pins(32'h0000_0105);
        rd(W_STATUS, 32'h0000_0100, "R5 rising");
        set_pins(32'h0000_0005);
        rd(W_STATUS, 32'h0000_0100, "R5 sticky after fall");
        wr(W_POL, 32'hFFFF_FDFF);
        set_pins(32'h0000_0205);
        rd(W_STATUS, 32'h0000_0100, "R5 rise ignored on falling pin");
        set_pins(32'h0000_0005);
        rd(W_STATUS, 32'h0000_0300, "R5 falling");
        wr(W_CLEAR, 32'h0000_0100);
        rd(W_STATUS, 32'h0000_0200, "R7 selective clear");
        rd(W_CLEAR, 32'h0, "R7 clear reads zero");
        // Any-edge
        wr(W_ANY, 32'h0000_0400);
        rd(W_ANY, 32'h0000_0400, "R6 any readback");
        expect_sig(4, W_ANY, 32'h0, "R11 rev2 any ignored");
        set_pins(32'h0000_0405);
        wr(W_CLEAR, 32'h0000_0600);
        rd(W_STATUS, 32'h0, "R7 clear pair");
        set_pins(32'h0000_0005);
        rd(W_STATUS, 32'h0000_0400, "R6 fall on any-edge pin");
        expect_sig(4, W_STATUS, 32'h0, "R11 rev2 no fall event");
        wr(W_ENABLE, 32'h0000_0400);
        wr(W_PEND, 32'h0);
        rd(W_PEND, 32'h0000_0400, "R8 pending write ignored");
        expect_sig(1, W_PEND, 32'h1, "R9 irq from edge");
        // Revision and unmapped
        wr(W_REV, 32'h55);
        rd(W_REV, 32'd3, "R10 revision read-only");
        rd(4'd10, 32'h0, "R12 unmapped");
        rd(4'd15, 32'h0, "R12 unmapped top");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule